// File: doc/BRIEF.md
# Multi-Channel DMA Transfer Engine

This block moves word-sized items on behalf of several independent channels through one bus master port, so that software is not involved for each item. Software sets up a channel through a small register write port with a start address for reading, a start address for writing, an item count, a trigger line, a direction, a per-side increment choice, a priority tier and a single-pass or circular mode. Writing the control register with its enable bit set starts the channel.

Channels that move between a peripheral and memory wait for their selected trigger line. A trigger line may come from a peripheral's data-ready request or from a timer event. The engine acknowledges the line while it writes the item. Memory-to-memory channels need no trigger and run back to back. Each item is a read followed by a write. After every item the bus is arbitrated again, and the higher tier wins. A single-pass channel stops after its count. A circular channel rewinds and reloads by itself. It raises a half flag at the midpoint and a full flag at each wrap. These completion flags, and never the individual items, drive one interrupt output.

Top module: `dma_multi_engine`

## Requirements
- R1: After reset no channel is busy, every flag is clear, the interrupt is low and the bus port is idle (read, write, address and write data all zero).
- R2: A channel whose direction code is 0 (peripheral to memory) or 1 (memory to peripheral) starts an item only while its selected trigger line (control bits [13:12]) is high. The engine raises the matching acknowledge during that item's write cycle. Direction codes 2 and 3 (memory to memory) start items without any trigger.
- R3: Each item is one bus read cycle at the channel's current read address, followed directly by one bus write cycle at its current write address, with the read data as write data. An idle cycle for arbitration comes between items.
- R4: After each item the read address advances by 4 when control bit 3 is set and the write address by 4 when control bit 4 is set. Otherwise each address holds.
- R5: A single-pass channel (control bit 5 clear) clears its busy bit and sets its full flag after exactly the programmed count of items.
- R6: A circular channel (control bit 5 set) stays busy on its last item. It sets its full flag, returns both addresses to their programmed starts and reloads the count.
- R7: A circular channel whose count is at least 2 sets its half flag when floor(count/2) items of the current pass have been moved. A single-pass channel never sets the half flag.
- R8: Among eligible channels, the highest tier (control bits [7:6], 3 highest) is granted. Equal tiers go to the lowest channel number. The grant lasts one item.
- R9: The flags stay set until software writes 1 to them at register 4 (bit 0 for half, bit 1 for full). A set in the same cycle wins over the clear. The interrupt is the OR over channels of the half flag gated by control bit 8 and the full flag gated by control bit 9.
- R10: A count write of zero is ignored and keeps the old count. Writes to registers 0 to 3 with the enable bit set on a busy channel are ignored. Enabling a channel whose count is zero is ignored.
- R11: Writing the control register with the enable bit clear on a busy channel stops it, and it issues no further items.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CHW | Channel addressed by the write |
| cfg_sel | input | 3 | Register: 0 read start, 1 write start, 2 count, 3 control, 4 flag clear |
| cfg_wdata | input | DW | Configuration write data |
| trig_req | input | NTRIG | Trigger lines from peripherals or timers |
| trig_ack | output | NTRIG | Acknowledge for the line being served |
| bus_rd | output | 1 | Bus read cycle |
| bus_wr | output | 1 | Bus write cycle |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Read data, valid the cycle after bus_rd |
| busy | output | NCH | Channel enabled and running |
| flag_half | output | NCH | Sticky half-pass flags |
| flag_full | output | NCH | Sticky completion flags |
| irq | output | 1 | Combined interrupt |

## Verification
The bench goes after the wrap point of a circular channel. A design that misses the reload would walk past the buffer or stop. It also checks the midpoint, where an off-by-one would move the half flag by an item. A busy channel is hit with new start addresses and a second enable; a design that took them would jump to the wrong address instead of rewinding to 0x300. Two tests cover arbitration. One has channels of equal tier raise their triggers together, where a wrong tie rule serves channel 1 first. In the other, a higher tier is enabled while a lower one is mid-run, and a grant that is held too long would finish the low-tier channel's items first. A zero count write and the sticky flags, both masked and unmasked, are checked as well, since a design that mishandled them would start a channel of length zero or lose a completion.

// File: rtl/dma_multi_engine.sv
module dma_multi_engine #(
  parameter int NCH   = 4,
  parameter int NTRIG = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int CW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(NCH)-1:0]   cfg_ch,
  input  logic [2:0]               cfg_sel,
  input  logic [DW-1:0]            cfg_wdata,
  input  logic [NTRIG-1:0]         trig_req,
  output logic [NTRIG-1:0]         trig_ack,
  output logic                     bus_rd,
  output logic                     bus_wr,
  output logic [AW-1:0]            bus_addr,
  output logic [DW-1:0]            bus_wdata,
  input  logic [DW-1:0]            bus_rdata,
  output logic [NCH-1:0]           busy,
  output logic [NCH-1:0]           flag_half,
  output logic [NCH-1:0]           flag_full,
  output logic                     irq
);
  localparam int CHW  = $clog2(NCH);
  localparam int TSW  = $clog2(NTRIG);
  localparam int CTLW = 12 + TSW;
  localparam int STEP = DW / 8;
  localparam logic [1:0] PH_IDLE = 2'd0, PH_RD = 2'd1, PH_WR = 2'd2;

  logic [AW-1:0]   sbase [NCH];
  logic [AW-1:0]   dbase [NCH];
  logic [AW-1:0]   sptr  [NCH];
  logic [AW-1:0]   dptr  [NCH];
  logic [CW-1:0]   cnt   [NCH];
  logic [CW-1:0]   rem   [NCH];
  logic [CTLW-1:0] ctl   [NCH];
  logic [NCH-1:0]  en, fh, ff;
  logic [1:0]      ph;
  logic [CHW-1:0]  cur, win;
  logic            win_ok;

  always_comb begin
    logic [1:0] best;
    win_ok = 1'b0;
    win    = '0;
    best   = '0;
    for (int c = 0; c < NCH; c++) begin
      if (en[c] && (ctl[c][2] || trig_req[ctl[c][12 +: TSW]]) &&
          (!win_ok || ctl[c][7:6] > best)) begin
        win_ok = 1'b1;
        win    = CHW'(c);
        best   = ctl[c][7:6];
      end
    end
  end

  wire            cur_circ = ctl[cur][5];
  wire            cur_last = rem[cur] == CW'(1);
  wire [CW-1:0]   nrem     = rem[cur] - CW'(1);
  wire [CW-1:0]   half_pt  = cnt[cur] - (cnt[cur] >> 1);

  assign bus_rd    = ph == PH_RD;
  assign bus_wr    = ph == PH_WR;
  assign bus_addr  = bus_rd ? sptr[cur] : bus_wr ? dptr[cur] : '0;
  assign bus_wdata = bus_wr ? bus_rdata : '0;
  assign busy      = en;
  assign flag_half = fh;
  assign flag_full = ff;

  always_comb begin
    irq = 1'b0;
    for (int c = 0; c < NCH; c++)
      irq = irq | (fh[c] & ctl[c][8]) | (ff[c] & ctl[c][9]);
    for (int t = 0; t < NTRIG; t++)
      trig_ack[t] = bus_wr && !ctl[cur][2] && ctl[cur][12 +: TSW] == TSW'(t);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      cur <= '0;
      en  <= '0;
      fh  <= '0;
      ff  <= '0;
      for (int c = 0; c < NCH; c++) begin
        sbase[c] <= '0; dbase[c] <= '0; sptr[c] <= '0; dptr[c] <= '0;
        cnt[c]   <= '0; rem[c]   <= '0; ctl[c]  <= '0;
      end
    end else begin
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: if (!en[cfg_ch]) sbase[cfg_ch] <= cfg_wdata[AW-1:0];
          3'd1: if (!en[cfg_ch]) dbase[cfg_ch] <= cfg_wdata[AW-1:0];
          3'd2: if (!en[cfg_ch] && cfg_wdata[CW-1:0] != '0) cnt[cfg_ch] <= cfg_wdata[CW-1:0];
          3'd3: begin
            if (!en[cfg_ch]) begin
              if (!cfg_wdata[0] || cnt[cfg_ch] != '0) ctl[cfg_ch] <= cfg_wdata[CTLW-1:0];
              if (cfg_wdata[0] && cnt[cfg_ch] != '0) begin
                en[cfg_ch]   <= 1'b1;
                sptr[cfg_ch] <= sbase[cfg_ch];
                dptr[cfg_ch] <= dbase[cfg_ch];
                rem[cfg_ch]  <= cnt[cfg_ch];
              end
            end else if (!cfg_wdata[0]) begin
              en[cfg_ch] <= 1'b0;
            end
          end
          3'd4: begin
            if (cfg_wdata[0]) fh[cfg_ch] <= 1'b0;
            if (cfg_wdata[1]) ff[cfg_ch] <= 1'b0;
          end
          default: ;
        endcase
      end
      case (ph)
        PH_IDLE: if (win_ok) begin cur <= win; ph <= PH_RD; end
        PH_RD:   ph <= PH_WR;
        default: begin
          ph <= PH_IDLE;
          if (cur_last) begin
            ff[cur] <= 1'b1;
            if (cur_circ) begin
              sptr[cur] <= sbase[cur];
              dptr[cur] <= dbase[cur];
              rem[cur]  <= cnt[cur];
            end else begin
              en[cur] <= 1'b0;
            end
          end else begin
            sptr[cur] <= sptr[cur] + (ctl[cur][3] ? AW'(STEP) : AW'(0));
            dptr[cur] <= dptr[cur] + (ctl[cur][4] ? AW'(STEP) : AW'(0));
            rem[cur]  <= nrem;
            if (cur_circ && cnt[cur] >= CW'(2) && nrem == half_pt) fh[cur] <= 1'b1;
          end
        end
      endcase
    end
  end

  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rst_n) bus_rd |=> bus_wr); // R3
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(trig_ack)); // R2
  AST_ACK_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (|trig_ack) |-> bus_wr); // R2
  AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) irq |-> |(flag_half | flag_full)); // R9
  AST_FULL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_full & ~$past(flag_full))) |-> $past(bus_wr)); // R5
  AST_HALF_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_half & ~$past(flag_half))) |-> $past(bus_wr)); // R7
endmodule

// File: tb/dma_multi_engine_tb.sv
module dma_multi_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  trig_req = '0;
  logic [3:0]  trig_ack;
  logic        bus_rd, bus_wr, irq;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata, rdata_q;
  logic [3:0]  busy, flag_half, flag_full;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_multi_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .trig_req(trig_req), .trig_ack(trig_ack),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(rdata_q), .busy(busy), .flag_half(flag_half), .flag_full(flag_full), .irq(irq));

  function automatic logic [31:0] ival(int i);
    return 32'hA500_0000 + 32'(i) * 32'h101;
  endfunction

  logic [31:0] smem [256];
  logic [31:0] mm   [256];
  initial for (int i = 0; i < 256; i++) begin smem[i] = ival(i); mm[i] = ival(i); end

  always @(posedge clk) begin
    if (bus_rd) rdata_q <= smem[bus_addr[9:2]];
    if (bus_wr) smem[bus_addr[9:2]] <= bus_wdata;
  end

  int m_sb[4], m_db[4], m_sp[4], m_dp[4], m_cnt[4], m_rem[4], m_ctl[4];
  bit m_en[4], m_fh[4], m_ff[4];
  int m_ph, m_cur;
  logic [31:0] m_rdv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_sb[c] = 0; m_db[c] = 0; m_sp[c] = 0; m_dp[c] = 0; m_cnt[c] = 0; m_rem[c] = 0;
        m_ctl[c] = 0; m_en[c] = 0; m_fh[c] = 0; m_ff[c] = 0;
      end
      m_ph = 0; m_cur = 0; m_rdv = '0;
    end else begin
      int w, bp, c0, ph0, k;
      w = -1; bp = -1; c0 = m_cur; ph0 = m_ph; k = int'(cfg_ch);
      for (int c = 0; c < 4; c++)
        if (m_en[c] && (((m_ctl[c] >> 1) & 3) >= 2 || trig_req[(m_ctl[c] >> 12) & 3]) &&
            ((m_ctl[c] >> 6) & 3) > bp) begin
          bp = (m_ctl[c] >> 6) & 3; w = c;
        end
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: if (!m_en[k]) m_sb[k] = int'(cfg_wdata[15:0]);
          3'd1: if (!m_en[k]) m_db[k] = int'(cfg_wdata[15:0]);
          3'd2: if (!m_en[k] && cfg_wdata[7:0] != 0) m_cnt[k] = int'(cfg_wdata[7:0]);
          3'd3: if (!m_en[k]) begin
                  if (!cfg_wdata[0] || m_cnt[k] != 0) m_ctl[k] = int'(cfg_wdata[13:0]);
                  if (cfg_wdata[0] && m_cnt[k] != 0) begin
                    m_en[k] = 1; m_sp[k] = m_sb[k]; m_dp[k] = m_db[k]; m_rem[k] = m_cnt[k];
                  end
                end else if (!cfg_wdata[0]) m_en[k] = 0;
          3'd4: begin if (cfg_wdata[0]) m_fh[k] = 0; if (cfg_wdata[1]) m_ff[k] = 0; end
          default: ;
        endcase
      end
      if (ph0 == 0) begin
        if (w >= 0) begin m_cur = w; m_ph = 1; end
      end else if (ph0 == 1) begin
        m_rdv = mm[(m_sp[c0] >> 2) & 255]; m_ph = 2;
      end else begin
        mm[(m_dp[c0] >> 2) & 255] = m_rdv; m_ph = 0;
        if (m_rem[c0] == 1) begin
          m_ff[c0] = 1;
          if ((m_ctl[c0] >> 5) & 1) begin
            m_sp[c0] = m_sb[c0]; m_dp[c0] = m_db[c0]; m_rem[c0] = m_cnt[c0];
          end else m_en[c0] = 0;
        end else begin
          if ((m_ctl[c0] >> 3) & 1) m_sp[c0] += 4;
          if ((m_ctl[c0] >> 4) & 1) m_dp[c0] += 4;
          m_rem[c0] -= 1;
          if (((m_ctl[c0] >> 5) & 1) && m_cnt[c0] >= 2 && m_rem[c0] == m_cnt[c0] - m_cnt[c0] / 2)
            m_fh[c0] = 1;
        end
      end
    end
  end

  int nchk = 0, nerr = 0;
  int ack_cnt[4];
  logic [15:0] rd_log[$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic compare_model();
    logic [15:0] ea; logic [31:0] ed; logic [3:0] eack, eb, eh, ef; logic ei;
    ea = (m_ph == 1) ? 16'(m_sp[m_cur]) : (m_ph == 2) ? 16'(m_dp[m_cur]) : 16'h0;
    ed = (m_ph == 2) ? m_rdv : 32'h0;
    eack = '0; ei = 0;
    if (m_ph == 2 && ((m_ctl[m_cur] >> 1) & 3) < 2) eack[(m_ctl[m_cur] >> 12) & 3] = 1'b1;
    for (int c = 0; c < 4; c++) begin
      eb[c] = m_en[c]; eh[c] = m_fh[c]; ef[c] = m_ff[c];
      ei = ei | (m_fh[c] & m_ctl[c][8]) | (m_ff[c] & m_ctl[c][9]);
    end
    chk(bus_rd == (m_ph == 1), "R3 bus_rd", bus_rd, m_ph == 1);
    chk(bus_wr == (m_ph == 2), "R3 bus_wr", bus_wr, m_ph == 2);
    chk(bus_addr == ea, "R4 bus_addr", bus_addr, ea);
    chk(bus_wdata == ed, "R3 bus_wdata", bus_wdata, ed);
    chk(trig_ack == eack, "R2 trig_ack", trig_ack, eack);
    chk(busy == eb, "R5 busy", busy, eb);
    chk(flag_half == eh, "R7 flag_half", flag_half, eh);
    chk(flag_full == ef, "R6 flag_full", flag_full, ef);
    chk(irq == ei, "R9 irq", irq, ei);
  endtask

  task automatic tick();
    @(negedge clk);
    if (rst_n) compare_model();
    if (bus_rd) rd_log.push_back(bus_addr);
    for (int t = 0; t < 4; t++)
      if (trig_ack[t]) begin ack_cnt[t]++; trig_req[t] = 1'b0; end
  endtask

  task automatic wr(input int ch, input int sel, input int data);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 3'(sel); cfg_wdata = 32'(data);
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic serve(input int t);
    trig_req[t] = 1'b1;
    repeat (5) tick();
  endtask

  task automatic wait_idle(input int ch);
    for (int i = 0; i < 60 && busy[ch]; i++) tick();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(busy == 0 && flag_half == 0 && flag_full == 0, "R1 reset flags", {busy, flag_half, flag_full}, 0);
    chk(!irq && !bus_rd && !bus_wr && bus_addr == 0 && bus_wdata == 0, "R1 reset bus",
        {irq, bus_rd, bus_wr, bus_addr, bus_wdata}, 0);

    // R3 R4 R5: memory-to-memory single pass, no trigger
    wr(0, 0, 'h000); wr(0, 1, 'h100); wr(0, 2, 4);
    wr(0, 3, 1 | (2 << 1) | (1 << 3) | (1 << 4) | (1 << 9));
    wait_idle(0);
    tick();
    chk(!busy[0] && flag_full[0], "R5 stop and full", {busy[0], flag_full[0]}, 2'b01);
    chk(!flag_half[0], "R7 no half in single pass", flag_half[0], 0);
    chk(irq, "R9 irq on full", irq, 1);
    for (int i = 0; i < 4; i++) chk(smem[64+i] == ival(i), "R4 copied word", smem[64+i], ival(i));
    wr(0, 4, 2); tick();
    chk(!flag_full[0] && !irq, "R9 clear by write one", {flag_full[0], irq}, 0);

    // R10: zero count keeps old count; masked flag polled
    wr(0, 2, 0); wr(0, 0, 'h010); wr(0, 1, 'h180);
    wr(0, 3, 1 | (2 << 1) | (1 << 3) | (1 << 4));
    wait_idle(0);
    tick();
    for (int i = 0; i < 4; i++) chk(smem[96+i] == ival(4+i), "R10 old count kept", smem[96+i], ival(4+i));
    chk(flag_full[0] && !irq, "R9 masked flag polled", {flag_full[0], irq}, 2'b10);
    wr(0, 4, 3);
    wr(3, 3, 1 | (2 << 1)); tick();
    chk(!busy[3], "R10 enable with zero count", busy[3], 0);

    // R2: peripheral to memory waits for trigger 2
    wr(1, 0, 'h200); wr(1, 1, 'h140); wr(1, 2, 3);
    wr(1, 3, 1 | (0 << 1) | (1 << 4) | (2 << 12));
    rd_log.delete();
    repeat (5) tick();
    chk(busy[1] && rd_log.size() == 0, "R2 no item without trigger", rd_log.size(), 0);
    for (int n = 0; n < 3; n++) serve(2);
    chk(ack_cnt[2] == 3, "R2 ack count", ack_cnt[2], 3);
    chk(!busy[1] && flag_full[1], "R5 peripheral pass done", {busy[1], flag_full[1]}, 2'b01);
    for (int i = 0; i < 3; i++) chk(smem[80+i] == ival(128), "R4 fixed read side", smem[80+i], ival(128));

    // R6 R7: circular memory to peripheral on trigger 1
    wr(2, 0, 'h300); wr(2, 1, 'h3F0); wr(2, 2, 4);
    wr(2, 3, 1 | (1 << 1) | (1 << 3) | (1 << 5) | (2 << 6) | (1 << 8) | (1 << 9) | (1 << 12));
    serve(1); serve(1);
    chk(flag_half[2] && !flag_full[2] && irq, "R7 half at midpoint", {flag_half[2], flag_full[2], irq}, 3'b101);
    wr(2, 4, 1);
    serve(1); serve(1);
    chk(flag_full[2] && busy[2], "R6 wrap keeps running", {flag_full[2], busy[2]}, 2'b11);
    chk(smem[252] == ival(195), "R4 fixed write side", smem[252], ival(195));
    wr(2, 0, 'h000); wr(2, 3, 1 | (2 << 1));
    rd_log.delete();
    serve(1);
    chk(rd_log.size() == 1 && rd_log[0] == 16'h300, "R6 R10 rewound, busy writes ignored",
        rd_log.size() ? rd_log[0] : 16'hFFFF, 16'h300);
    wr(2, 3, 0); tick();
    chk(!busy[2], "R11 stop by disable", busy[2], 0);
    rd_log.delete();
    trig_req[1] = 1'b1;
    repeat (6) tick();
    chk(rd_log.size() == 0, "R11 no item after stop", rd_log.size(), 0);
    trig_req[1] = 1'b0;

    // R8: higher tier preempts at item boundary
    wr(0, 0, 'h040); wr(0, 1, 'h1C0); wr(0, 2, 2);
    wr(3, 0, 'h060); wr(3, 1, 'h1E0); wr(3, 2, 2);
    rd_log.delete();
    wr(0, 3, 1 | (2 << 1) | (1 << 3) | (1 << 4) | (1 << 6));
    wr(3, 3, 1 | (2 << 1) | (1 << 3) | (1 << 4) | (3 << 6));
    repeat (20) tick();
    chk(rd_log.size() == 4, "R8 item count", rd_log.size(), 4);
    if (rd_log.size() == 4) begin
      chk(rd_log[0] == 16'h040, "R8 first grant", rd_log[0], 16'h040);
      chk(rd_log[1] == 16'h060, "R8 tier 3 next", rd_log[1], 16'h060);
      chk(rd_log[2] == 16'h064, "R8 tier 3 again", rd_log[2], 16'h064);
      chk(rd_log[3] == 16'h044, "R8 tier 1 resumes", rd_log[3], 16'h044);
    end

    // R8: equal tiers, lowest channel first
    wr(0, 0, 'h080); wr(0, 1, 'h1A0); wr(0, 2, 1);
    wr(1, 0, 'h0A0); wr(1, 1, 'h1A8); wr(1, 2, 1);
    wr(0, 3, 1 | (1 << 4) | (1 << 6) | (0 << 12));
    wr(1, 3, 1 | (1 << 4) | (1 << 6) | (3 << 12));
    rd_log.delete();
    trig_req = 4'b1001;
    repeat (10) tick();
    chk(rd_log.size() == 2 && rd_log[0] == 16'h080, "R8 tie to lowest",
        rd_log.size() ? rd_log[0] : 16'hFFFF, 16'h080);
    if (rd_log.size() == 2) chk(rd_log[1] == 16'h0A0, "R8 tie second", rd_log[1], 16'h0A0);

    finish_run();
  end
endmodule